// File: doc/BRIEF.md
# Serial-Programmed Control Register Bank

This block is a mode-0 serial slave that gives an external controller read and write access to a bank of byte-wide control registers. The registers hold settings such as capacitor-array codes and multiplexer selects. Each register drives its contents onto a wide parallel bus, where the analog and test logic consume it. The logic runs only on the serial clock, so the block draws no power between transactions. The active-low select line frames each transaction and clears all frame state asynchronously.

A frame begins with one direction bit, where 1 means read and 0 means write. Seven address bits follow, most significant bit first. After that come any number of data bytes, each most significant bit first. After every data byte the address advances by one and wraps from 127 to 0, so one frame can cover a run of consecutive registers. Only the lowest `NREG` addresses are implemented. A write to any higher address is dropped, and a read from one returns zero.

Top module: `spi_regbank`

## Requirements
- R1: While `rst_n` is low, every register reads 0x00 and `reg_bus` is all zeros.
- R2: A frame whose first bit is 0 is a write. The next 7 bits form the address, MSB first, and each following byte is stored MSB first.
- R3: A written byte appears on `reg_bus` right after the rising SCLK edge that captures its eighth bit, and not before that edge.
- R4: In a write frame, each further byte goes to the next address.
- R5: A frame whose first bit is 1 is a read. The first data bit appears on `miso` at the falling edge after the last address bit, and bytes are sent MSB first.
- R6: In a read frame, each further byte comes from the next address.
- R7: The address wraps from 127 to 0 during auto-increment.
- R8: Raising `cs_n` in the middle of a byte discards that byte and writes nothing. The next frame starts cleanly from its first bit.
- R9: `miso_oe` is low while the direction and address bits are being shifted in, during write frames and while the block is deselected. `miso` is 0 whenever `miso_oe` is low.
- R10: A write to an address at or above `NREG` changes no register, and a read from such an address returns 0x00.
- R11: Register k appears on `reg_bus[8k+7:8k]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low register reset |
| sclk | input | 1 | Serial clock, idles low |
| cs_n | input | 1 | Active-low select; high clears frame state |
| mosi | input | 1 | Serial data in, sampled on rising SCLK |
| miso | output | 1 | Serial data out, changes on falling SCLK |
| miso_oe | output | 1 | High while `miso` carries read data |
| reg_bus | output | NREG*8 | All registers, register k at bits 8k+7:8k |

## Verification
The bench samples `reg_bus` on both sides of the eighth rising edge of a data byte. A design that commits a byte one edge early, or that waits for the falling edge, fails that check. A burst that starts at address 127 checks the wrap and the out-of-range rules together. A design that carries the increment into an eighth bit, or that writes a shadow register, shows the wrong byte in register 0 or a non-zero read. A frame cut off after five data bits, followed by a read of the same address, catches designs that commit partial bytes or keep a stale bit count. Read bursts are compared byte by byte against a model, and `miso_oe` is checked during every header bit.

// File: rtl/spi_regbank.sv
module spi_regbank #(
  parameter int NREG = 32,
  parameter int DW   = 8
) (
  input  logic               rst_n,
  input  logic               sclk,
  input  logic               cs_n,
  input  logic               mosi,
  output logic               miso,
  output logic               miso_oe,
  output logic [NREG*DW-1:0] reg_bus
);
  localparam int AW = DW - 1;
  localparam int CW = $clog2(DW);
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

  logic [DW-1:0] regs [NREG];
  logic [CW-1:0] bcnt;
  logic          hdr, rd;
  logic [DW-2:0] sh;
  logic [AW-1:0] addr;
  logic [DW-1:0] tx, rdata;
  logic          last, hit, wr_en;

  assign last  = (bcnt == CW'(DW - 1));
  assign hit   = ({1'b0, addr} < (AW + 1)'(NREG));
  assign wr_en = !hdr && !rd && last;
  assign rdata = hit ? regs[addr[IW-1:0]] : '0;
  assign miso  = miso_oe & tx[DW-1];

  always_ff @(posedge sclk or posedge cs_n) begin
    if (cs_n) begin
      bcnt <= '0;
      hdr  <= 1'b1;
      rd   <= 1'b0;
    end else begin
      bcnt <= bcnt + 1'b1;
      if (hdr && bcnt == '0) rd <= mosi;
      if (last) hdr <= 1'b0;
    end
  end

  always_ff @(posedge sclk) begin
    sh <= {sh[DW-3:0], mosi};
    if (last) addr <= hdr ? {sh[AW-2:0], mosi} : addr + 1'b1;
  end

  always_ff @(negedge sclk or posedge cs_n) begin
    if (cs_n) begin
      tx      <= '0;
      miso_oe <= 1'b0;
    end else if (!hdr && bcnt == '0) begin
      tx      <= rdata;
      miso_oe <= rd;
    end else begin
      tx <= {tx[DW-2:0], 1'b0};
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge sclk or negedge rst_n) begin
      if (!rst_n)
        regs[g] <= '0;
      else if (wr_en && hit && addr[IW-1:0] == IW'(g))
        regs[g] <= {sh, mosi};
    end
    assign reg_bus[g*DW +: DW] = regs[g];
  end
endmodule

module spi_regbank_chk #(
  parameter int BW = 256
) (
  input logic          rst_n,
  input logic          sclk,
  input logic          hdr,
  input logic          rd,
  input logic          wr_en,
  input logic          miso_oe,
  input logic [BW-1:0] reg_bus
);
  logic armed = 1'b0;
  always @(posedge sclk) armed <= 1'b1;

  always @(posedge sclk)
    if (!rst_n) assert_reset_clear_R1: assert (reg_bus == '0);

  assert_bus_only_on_write_R3: assert property (@(posedge sclk) disable iff (!rst_n)
    (armed && !$stable(reg_bus)) |-> $past(wr_en));

  assert_oe_in_read_R5: assert property (@(negedge sclk) disable iff (!rst_n)
    miso_oe |-> rd);

  assert_no_oe_in_header_R9: assert property (@(posedge sclk) disable iff (!rst_n)
    hdr |-> !miso_oe);
endmodule

bind spi_regbank spi_regbank_chk #(.BW(NREG*DW)) u_chk (
  .rst_n(rst_n), .sclk(sclk), .hdr(hdr), .rd(rd), .wr_en(wr_en),
  .miso_oe(miso_oe), .reg_bus(reg_bus)
);

// File: tb/spi_regbank_bench.sv
module spi_regbank_bench;
  localparam int NREG = 32;

  logic clk = 0;
  logic rst_n, sclk, cs_n, mosi;
  logic miso, miso_oe;
  logic [NREG*8-1:0] reg_bus;

  always #5 clk = ~clk;

  spi_regbank #(.NREG(NREG), .DW(8)) u_spi_regbank (
    .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .reg_bus(reg_bus)
  );

  int n_cmp = 0, n_bad = 0;
  logic [7:0] mdl [128];
  logic [7:0] exp_q [$];
  logic [7:0] rx_q [$];
  string      tag_q [$];

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_bus(input string tag);
    for (int k = 0; k < NREG; k++)
      chk(reg_bus[k*8 +: 8] === mdl[k], tag, {24'd0, reg_bus[k*8 +: 8]}, {24'd0, mdl[k]});
  endtask

  task automatic rise(input logic b, output logic s, output logic oe);
    @(negedge clk) mosi = b;
    repeat (2) @(negedge clk);
    s = miso; oe = miso_oe;
    sclk = 1;
    @(negedge clk);
  endtask

  task automatic fall;
    @(negedge clk) sclk = 0;
  endtask

  task automatic header(input logic rw, input logic [6:0] a);
    logic s, oe;
    @(negedge clk) cs_n = 0;
    for (int i = 0; i < 8; i++) begin
      rise((i == 0) ? rw : a[7-i], s, oe);
      chk(oe === 1'b0, "R9 header oe", {31'd0, oe}, 0);
      fall();
    end
  endtask

  task automatic stop;
    @(negedge clk) cs_n = 1;
    repeat (3) @(negedge clk);
    chk(miso_oe === 1'b0 && miso === 1'b0, "R9 idle", {30'd0, miso_oe, miso}, 0);
  endtask

  task automatic put_byte(input logic [7:0] d);
    logic s, oe;
    for (int b = 7; b >= 0; b--) begin rise(d[b], s, oe); fall(); end
  endtask

  task automatic spi_write(input logic [6:0] a, input logic [7:0] d [4], input int n);
    header(1'b0, a);
    for (int i = 0; i < n; i++) begin
      put_byte(d[i]);
      if (int'(7'(a + i)) < NREG) mdl[7'(a + i)] = d[i];
    end
    stop();
  endtask

  task automatic spi_read(input logic [6:0] a, input int n, input string tag);
    logic s, oe;
    logic [7:0] v;
    header(1'b1, a);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(mdl[7'(a + i)]);
      tag_q.push_back(tag);
      for (int b = 7; b >= 0; b--) begin
        rise(1'b0, s, oe);
        v[b] = s;
        chk(oe === 1'b1, "R5 oe during data", {31'd0, oe}, 1);
        fall();
      end
      rx_q.push_back(v);
    end
    stop();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      while (rx_q.size() > 0 && exp_q.size() > 0) begin
        logic [7:0] g, e;
        string t;
        g = rx_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
        chk(g === e, t, {24'd0, g}, {24'd0, e});
      end
    end
  end

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] d [4];
    logic s, oe;
    for (int k = 0; k < 128; k++) mdl[k] = 8'h00;
    rst_n = 0; cs_n = 1; sclk = 0; mosi = 0;
    repeat (4) @(negedge clk);
    chk_bus("R1 reset");
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2 / R3: single write with edge-exact check
    header(1'b0, 7'd3);
    for (int b = 7; b >= 1; b--) begin rise(8'hA5 >> b, s, oe); fall(); end
    chk(reg_bus[3*8 +: 8] === 8'h00, "R3 before 8th edge", {24'd0, reg_bus[3*8 +: 8]}, 0);
    rise(1'b1, s, oe);
    @(negedge clk);
    chk(reg_bus[3*8 +: 8] === 8'hA5, "R3 after 8th edge", {24'd0, reg_bus[3*8 +: 8]}, 32'hA5);
    fall();
    stop();
    mdl[3] = 8'hA5;
    chk_bus("R2 R11 single write");

    // R4 burst write
    d = '{8'h11, 8'h22, 8'h33, 8'h44};
    spi_write(7'd10, d, 4);
    chk_bus("R4 burst write");

    // R5 / R6 reads
    spi_read(7'd3, 1, "R5 single read");
    spi_read(7'd10, 4, "R6 burst read");

    // R7 wrap and R10 out-of-range
    d = '{8'h77, 8'h5C, 8'h6D, 8'h00};
    spi_write(7'd127, d, 3);
    chk_bus("R7 wrap write");
    spi_read(7'd126, 4, "R7 R10 wrap read");
    d = '{8'hFF, 8'hEE, 8'h00, 8'h00};
    spi_write(7'd40, d, 2);
    chk_bus("R10 ignored write");
    spi_read(7'd31, 2, "R10 edge read");

    // R8 aborted byte
    header(1'b0, 7'd3);
    for (int b = 0; b < 5; b++) begin rise(1'b0, s, oe); fall(); end
    stop();
    chk_bus("R8 partial byte");
    spi_read(7'd3, 1, "R8 clean next frame");

    d = '{8'hC3, 8'h3C, 8'h00, 8'h00};
    spi_write(7'd31, d, 2);
    chk_bus("R11 top register");

    @(negedge clk) rst_n = 0;
    for (int k = 0; k < 128; k++) mdl[k] = 8'h00;
    @(negedge clk);
    chk_bus("R1 second reset");
    rst_n = 1;

    repeat (5) @(posedge clk);
    chk(exp_q.size() == 0 && rx_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule